// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer that sits on a 32-bit register bus with byte enables. Software programs a control word that holds a run bit, a stored-only clock-choice field, a stored-only window-mode bit and a timeout exponent. While the run bit is set, the input clock passes through a fixed divide-by-32 stage. The resulting ticks are counted until the count reaches two raised to the exponent. At that point the block raises a reset request for one cycle, records the cause in a sticky status word and starts a new period.

The only way to restart the period is a half-word write of the key 0x5743 into the upper half of the control word. Every other write leaves the count alone. The control word has a clear alias and a set alias, so single bits can be changed without a read-modify-write. The status word has a clear alias that software uses to acknowledge a timeout. When the run bit is turned off, the bus is locked out for one cycle.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset, the control word and the status word read as zero and `wdt_rst_o` is low.
- R2: The control word is at byte offset 0x00. Its stored bits are run at bit 15, exponent at bits 12:8, clock choice at bits 7:6 and window mode at bit 0. A write replaces only the bytes whose enable is high. All other bits, including 31:16, read as zero.
- R3: A write to offset 0x04 clears, and a write to offset 0x08 sets, exactly the control bits written as 1 in enabled bytes. All other bits are left unchanged. Both aliases read back the control word.
- R4: While run is 1, `wdt_rst_o` is high for exactly one cycle after every 32·2^exponent cycles, counted from the edge that set run or from the last restart.
- R5: A write to offset 0x00 with both upper byte enables high and data bits 31:16 equal to 0x5743 restarts the full period.
- R6: An upper-half write with any other value, or with the key but only one upper byte enable, does not change the count.
- R7: While run is 0, the count is held at zero and no request is raised. Setting run again starts a full period.
- R8: The status word is at offset 0x10. A timeout sets the sticky bit 4. It also sets bit 2 if `idle_i` is high, and bit 3 if `sleep_i` is high, in the expiring cycle. Bits 2 and 3 are sticky as well.
- R9: A write to offset 0x14 with byte 0 enabled clears the status bits written as 1. Without byte 0 enabled it has no effect. A timeout in the same cycle wins over the clear.
- R10: In the cycle right after a write clears run, bus writes are ignored and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| idle_i | input | 1 | Low-power idle indication |
| sleep_i | input | 1 | Low-power sleep indication |
| bus_rdata | output | 32 | Read data, combinational for the current read |
| wdt_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
A behavioural model counts cycles since the period last started and predicts the request output every cycle. The first pattern lets the timer run free with exponents 1 and 0, which tests the divide-by-32 stage and the power-of-two terminal. The second pattern writes the key regularly, which must suppress every request. Decoy upper-half writes and a partially enabled key must leave the period exactly where it was. Turning run off, turning it on again and accessing the bus right after turning run off separate a held count from a paused one and show the lockout cycle. Byte-masked writes to the aliases show that unwritten bits keep their values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W        = 32;
    localparam int BE_W          = DATA_W / 8;
    localparam int PRESCALE_LOG2 = 5;
    localparam int PS_W          = 5;
    localparam int CS_W          = 2;

    localparam logic [15:0] KICK_KEY = 16'h5743;

    localparam int OFF_CTRL     = 'h00;
    localparam int OFF_CTRL_CLR = 'h04;
    localparam int OFF_CTRL_SET = 'h08;
    localparam int OFF_STAT     = 'h10;
    localparam int OFF_STAT_CLR = 'h14;

    localparam int RUN_BIT  = 15;
    localparam int PS_LO    = 8;
    localparam int CS_LO    = 6;
    localparam int WIN_BIT  = 0;
    localparam int ST_IDLE  = 2;
    localparam int ST_SLEEP = 3;
    localparam int ST_TMO   = 4;

    typedef struct packed {
        logic            run;
        logic [PS_W-1:0] ps;
        logic [CS_W-1:0] cs;
        logic            win;
    } ctrl_t;

    typedef struct packed {
        logic tmo;
        logic sleep;
        logic idle;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[RUN_BIT]        = c.run;
        w[PS_LO +: PS_W]  = c.ps;
        w[CS_LO +: CS_W]  = c.cs;
        w[WIN_BIT]        = c.win;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run = w[RUN_BIT];
        c.ps  = w[PS_LO +: PS_W];
        c.cs  = w[CS_LO +: CS_W];
        c.win = w[WIN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input stat_t s);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[ST_TMO]   = s.tmo;
        w[ST_SLEEP] = s.sleep;
        w[ST_IDLE]  = s.idle;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  stat_t             stat_i,
    output ctrl_t             ctrl_o,
    output logic              kick_o,
    output logic [2:0]        stat_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctrl_t             ctrl_q, ctrl_d;
    logic              lock_q, lock_d;
    logic              wr_ok;
    logic [DATA_W-1:0] lane_mask, cur_w, nxt_w, wmask;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{be[g]}};
    end

    assign wr_ok = req && we && !lock_q;
    assign cur_w = pack_ctrl(ctrl_q);
    assign wmask = wdata & lane_mask;

    always_comb begin
        nxt_w = cur_w;
        if (wr_ok) begin
            case (addr)
                ADDR_W'(OFF_CTRL):     nxt_w = (cur_w & ~lane_mask) | wmask;
                ADDR_W'(OFF_CTRL_CLR): nxt_w = cur_w & ~wmask;
                ADDR_W'(OFF_CTRL_SET): nxt_w = cur_w | wmask;
                default:               nxt_w = cur_w;
            endcase
        end
        ctrl_d = unpack_ctrl(nxt_w);
        lock_d = wr_ok && ctrl_q.run && !ctrl_d.run;
    end

    assign kick_o = wr_ok && (addr == ADDR_W'(OFF_CTRL)) && (be[BE_W-1 -: 2] == 2'b11)
                    && (wdata[DATA_W-1 -: 16] == KICK_KEY);

    assign stat_clr_o = (wr_ok && (addr == ADDR_W'(OFF_STAT_CLR)) && be[0])
                        ? wdata[ST_TMO:ST_IDLE] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lock_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            lock_q <= lock_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (req && !we && !lock_q) begin
            case (addr)
                ADDR_W'(OFF_CTRL),
                ADDR_W'(OFF_CTRL_CLR),
                ADDR_W'(OFF_CTRL_SET): rdata_o = cur_w;
                ADDR_W'(OFF_STAT),
                ADDR_W'(OFF_STAT_CLR): rdata_o = pack_stat(stat_i);
                default:               rdata_o = '0;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;

    // R10: lockout cycle freezes the control word
    a_r10_lock_freeze: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(ctrl_q));

    // R10: lockout follows a falling run bit
    a_r10_lock_after_stop: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !ctrl_q.run);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRE_LOG2 = PRESCALE_LOG2,
    parameter int PSW      = PS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_i,
    input  logic [PSW-1:0] ps_i,
    input  logic           kick_i,
    output logic           expire_o,
    output logic           rst_req_o
);

    localparam int CNT_W = 2 ** PSW;

    logic [PRE_LOG2-1:0] pre_q;
    logic [CNT_W-1:0]    cnt_q, term_m1;
    logic                tick, rst_q;

    assign tick     = &pre_q;
    assign term_m1  = (CNT_W'(1) << ps_i) - CNT_W'(1);
    assign expire_o = run_i && !kick_i && tick && (cnt_q == term_m1);

    always_ff @(posedge clk) begin
        if (rst || !run_i || kick_i || expire_o) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (tick) cnt_q <= cnt_q + 1'b1;
        end
        rst_q <= rst ? 1'b0 : expire_o;
    end

    assign rst_req_o = rst_q;

    // R4: request is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_q |=> !rst_q);

    // R7: no request while stopped
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !rst_q);

    // R5: a key write restarts both stages
    a_r5_kick_restart: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (pre_q == '0 && cnt_q == '0));

endmodule

// File: rtl/wdt_status.sv
module wdt_status
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_i,
    input  logic       idle_i,
    input  logic       sleep_i,
    input  logic [2:0] clr_i,
    output stat_t      stat_o
);

    stat_t stat_q, stat_d;

    always_comb begin
        stat_d = stat_t'(stat_q & ~stat_t'(clr_i));
        if (set_i) begin
            stat_d.tmo   = 1'b1;
            stat_d.idle  = stat_d.idle  | idle_i;
            stat_d.sleep = stat_d.sleep | sleep_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R8: timeout flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q.tmo && !clr_i[2]) |=> stat_q.tmo);

    // R9: clear without a coincident timeout drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i[2] && !set_i) |=> !stat_q.tmo);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    input  logic              idle_i,
    input  logic              sleep_i,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_o
);

    ctrl_t      ctrl;
    stat_t      stat;
    logic       kick, expire;
    logic [2:0] stat_clr;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .be         (bus_be),
        .wdata      (bus_wdata),
        .stat_i     (stat),
        .ctrl_o     (ctrl),
        .kick_o     (kick),
        .stat_clr_o (stat_clr),
        .rdata_o    (bus_rdata)
    );

    wdt_timer #(.PRE_LOG2(PRESCALE_LOG2), .PSW(PS_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctrl.run),
        .ps_i      (ctrl.ps),
        .kick_i    (kick),
        .expire_o  (expire),
        .rst_req_o (wdt_rst_o)
    );

    wdt_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_i   (expire),
        .idle_i  (idle_i),
        .sleep_i (sleep_i),
        .clr_i   (stat_clr),
        .stat_o  (stat)
    );

    // R8: every request is accompanied by the sticky flag
    a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> stat.tmo);

    // R2: upper half always reads zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == 16'h0000);

endmodule

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        idle_i = 1'b0, sleep_i = 1'b0;
    logic [31:0] rdata;
    logic        wdt_rst;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string cur_tag = "R4";

    // behavioural reference state
    logic [31:0] m_ctrl = '0, m_stat = '0;
    bit          m_busy = 0, m_rst = 0;
    int          m_el = 0;

    always #2 clk = ~clk;

    keyed_wdt uut (
        .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_be(be), .bus_wdata(wdata), .idle_i(idle_i), .sleep_i(sleep_i),
        .bus_rdata(rdata), .wdt_rst_o(wdt_rst)
    );

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ctrl = '0; m_stat = '0; m_busy = 0; m_rst = 0; m_el = 0;
        end else begin
            bit wr, kick, ev;
            logic [31:0] lm, nc;
            wr   = req && we && !m_busy;
            kick = wr && addr == 5'h00 && be[3:2] == 2'b11 && wdata[31:16] == 16'h5743;
            ev   = 0;
            if (!m_ctrl[15] || kick) m_el = 0;
            else begin
                m_el++;
                if (m_el == (32 << m_ctrl[12:8])) begin ev = 1; m_el = 0; end
            end
            if (wr && addr == 5'h14 && be[0]) m_stat = m_stat & ~(wdata & 32'h1C);
            if (ev) m_stat = m_stat | 32'h10 | (idle_i ? 32'h4 : 32'h0) | (sleep_i ? 32'h8 : 32'h0);
            lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            nc = m_ctrl;
            if (wr) begin
                if (addr == 5'h00) nc = (m_ctrl & ~lm) | (wdata & lm);
                else if (addr == 5'h04) nc = m_ctrl & ~(wdata & lm);
                else if (addr == 5'h08) nc = m_ctrl | (wdata & lm);
            end
            nc = nc & 32'h0000_9FC1;
            m_busy = wr && m_ctrl[15] && !nc[15];
            m_ctrl = nc;
            m_rst  = ev;
        end
    end

    // per-cycle comparison of the request output (R4, R5, R6, R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (wdt_rst !== m_rst) begin
                fails++;
                $display("FAIL %s request at cycle %0d: actual %0b expected %0b", cur_tag, cyc, wdt_rst, m_rst);
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (m_busy) return 32'h0;
        if (a == 5'h00 || a == 5'h04 || a == 5'h08) return m_ctrl;
        if (a == 5'h10 || a == 5'h14) return m_stat;
        return 32'h0;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d; be = b;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        req = 1; we = 0; addr = a; be = 4'hF; wdata = '0;
        #1;
        exp = model_read(a);
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s read @%02h: actual %08h expected %08h", tag, a, rdata, exp);
        end
    endtask

    task automatic idle_cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            req = 0; we = 0;
        end
    endtask

    task automatic report;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state
        checks++;
        if (wdt_rst !== 1'b0) begin
            fails++; $display("FAIL R1 request: actual %0b expected 0", wdt_rst);
        end
        rd(5'h00, "R1");
        rd(5'h10, "R1");
        // R2: full write keeps only defined bits, upper half reads zero
        wr(5'h00, 32'hFFFF_FFFF, 4'hF);
        rd(5'h00, "R2");
        // R2 byte lane write that also stops the timer; R10 lockout
        wr(5'h00, 32'h0000_0000, 4'b0010);
        wr(5'h00, 32'hFFFF_FFFF, 4'hF);
        rd(5'h00, "R10");
        wr(5'h08, 32'h0000_8000, 4'b0010);
        wr(5'h04, 32'h0000_8000, 4'b0010);
        rd(5'h00, "R10");
        rd(5'h00, "R2");
        // R3: aliases
        wr(5'h04, 32'h0000_00C0, 4'b0001);
        wr(5'h08, 32'h0000_0100, 4'b0010);
        wr(5'h08, 32'hFFFF_FF00, 4'b1100);
        rd(5'h08, "R3");
        rd(5'h04, "R3");
        // R4: free running with exponent 1
        cur_tag = "R4";
        wr(5'h08, 32'h0000_8000, 4'b0010);
        idle_cyc(140);
        rd(5'h10, "R8");
        // R5: regular key writes
        cur_tag = "R5";
        repeat (6) begin
            idle_cyc(40);
            wr(5'h00, 32'h5743_0000, 4'b1100);
        end
        // R6: decoys, then expiry with idle high (R8)
        cur_tag = "R6";
        idle_i = 1;
        wr(5'h00, 32'h1234_0000, 4'b1100);
        wr(5'h00, 32'h5743_0000, 4'b1000);
        wr(5'h00, 32'h5743_0000, 4'b0100);
        idle_cyc(70);
        idle_i = 0;
        rd(5'h10, "R8");
        sleep_i = 1;
        idle_cyc(64);
        sleep_i = 0;
        rd(5'h10, "R8");
        // R9: status clear alias
        cur_tag = "R9";
        wr(5'h04, 32'h0000_8000, 4'b0010);
        idle_cyc(2);
        wr(5'h14, 32'h0000_0010, 4'b0001);
        rd(5'h10, "R9");
        wr(5'h14, 32'h0000_001C, 4'b0010);
        rd(5'h10, "R9");
        wr(5'h14, 32'h0000_001C, 4'b0001);
        rd(5'h10, "R9");
        // R7: stopped timer stays quiet, restart gives full period
        cur_tag = "R7";
        idle_cyc(200);
        rd(5'h10, "R7");
        wr(5'h08, 32'h0000_8000, 4'b0010);
        idle_cyc(70);
        // R4: exponent 0
        cur_tag = "R4";
        wr(5'h04, 32'h0000_8000, 4'b0010);
        idle_cyc(1);
        wr(5'h04, 32'h0000_0100, 4'b0010);
        wr(5'h08, 32'h0000_8000, 4'b0010);
        idle_cyc(100);
        rd(5'h00, "R4");
        report();
    end

endmodule